// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is the timekeeping register bank of a real-time clock. It keeps seconds, minutes, hours, weekday, day of month, month and a two-digit year in packed BCD, along with a control byte and a century flag. All of it is reached through a single byte-wide port with a three-bit address. A write stores a byte on the next clock edge. A read is combinational: it returns the packed BCD byte of the addressed register.

A one-cycle `tick_1hz` pulse advances the time by one second. The carry ripples through minutes, hours, weekday, date, month and year, and follows month lengths and leap years. Each time field checks its own write range and drops a value that is out of range. Bit 7 of the seconds register is a stop flag: while it is set, ticks are ignored and the time is held.

Address map: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the bank holds 00:00:00, date 01, month 01, year 00, weekday 1, century 0, stop 0 and control 0x00.
- R2: A write to seconds (addr 1) or minutes (addr 2) takes bits 6:0 and stores them only when both nibbles are decimal digits and the value is 0x00..0x59. A seconds write always copies data bit 7 into the stop flag, whether or not the time value is accepted.
- R3: A write to hours (addr 3) takes bits 5:0 and stores them only when both nibbles are decimal and the value is 0x00..0x23.
- R4: A date write (addr 5) takes bits 5:0 and is accepted when the value is decimal and nonzero. A month write (addr 6) takes bits 4:0 and is accepted only for 0x01..0x12. A year write (addr 7) takes all 8 bits and is accepted only for 0x00..0x99. A rejected write leaves the register unchanged.
- R5: While the stop flag is set, ticks change no time field. Clearing it resumes counting from the held time. Reading seconds returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R6: A write to addr 4 sets the weekday from bits 2:0 and the century flag from bit 6. A read returns the century flag in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R7: A control write (addr 0) stores the data with bits 7 and 5 cleared, then bits 7 and 4 set. A read returns the stored byte.
- R8: A tick with the stop flag clear advances seconds in BCD. 59 wraps to 00 and carries into minutes, minutes 59 carries into hours, and hours 23 carries into the day. A day carry advances the weekday, with 7 wrapping to 1.
- R9: On a day carry, a date equal to or beyond the month length becomes 01 and carries into the month. The month length is 31, or 30 for months 4, 6, 9 and 11, and for month 2 it is 29 when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R10: A write to any of addresses 1..7 in the same cycle as a tick takes precedence, and that tick is discarded, so it causes no increment and no carry. A control write does not suppress a tick.
- R11: Minutes, hours, date, month and year read back as their stored BCD value, zero-extended to 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | AW | Register select |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte of the addressed register (combinational) |

## Verification
Directed rollovers check the carry chain and month-length logic, which a random walk rarely reaches. The full chain is driven from 23:59:59 on 31 Dec 99. February is tested in a leap year and in a common year, on day 28 and on day 29, and the end of a 30-day month is tested too; together these separate the three month lengths and the leap rule. Writes just outside each field's range (0x60, 0x5A, 0x24, date 0, month 0x13, year 0x9A) show the validation works field by field. A write that lands in the same cycle as a tick shows that the write wins and no carry leaks out. A seeded random mix of ticks, stop toggles and raw or BCD-shaped writes is then compared against a binary-integer reference model, to catch interactions that the directed cases do not reach.

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SEC  = AW'(1);
  localparam logic [AW-1:0] A_MIN  = AW'(2);
  localparam logic [AW-1:0] A_HR   = AW'(3);
  localparam logic [AW-1:0] A_WDAY = AW'(4);
  localparam logic [AW-1:0] A_DATE = AW'(5);
  localparam logic [AW-1:0] A_MON  = AW'(6);
  localparam logic [AW-1:0] A_YR   = AW'(7);

  logic [7:0] ctrl_q, sec_q, min_q, hr_q, wday_q, date_q, mon_q, yr_q;
  logic       stop_q, cent_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic dec_in(input logic [7:0] v, input logic [7:0] lo, input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  logic wr_time, adv, c_min, c_hr, c_day, c_mon, c_yr, leap;
  logic [7:0] last_day;

  assign wr_time = wr_en && (addr != A_CTRL);
  assign adv     = tick_1hz && !stop_q && !wr_time;
  assign c_min   = adv && (sec_q == 8'h59);
  assign c_hr    = c_min && (min_q == 8'h59);
  assign c_day   = c_hr && (hr_q == 8'h23);
  assign leap    = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                           : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c_mon = c_day && (date_q >= last_day);
  assign c_yr  = c_mon && (mon_q == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00; sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      wday_q <= 8'h01; date_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00;
      stop_q <= 1'b0;  cent_q <= 1'b0;
    end else begin
      if (adv)   sec_q <= c_min ? 8'h00 : bcd_inc(sec_q);
      if (c_min) min_q <= c_hr ? 8'h00 : bcd_inc(min_q);
      if (c_hr)  hr_q  <= c_day ? 8'h00 : bcd_inc(hr_q);
      if (c_day) begin
        wday_q <= (wday_q >= 8'd7) ? 8'd1 : wday_q + 8'd1;
        date_q <= c_mon ? 8'h01 : bcd_inc(date_q);
      end
      if (c_mon) mon_q <= c_yr ? 8'h01 : bcd_inc(mon_q);
      if (c_yr)  yr_q  <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
      if (wr_en) begin
        case (addr)
          A_CTRL: ctrl_q <= (wr_data & ~8'hA0) | 8'h90;
          A_SEC: begin
            stop_q <= wr_data[7];
            if (dec_in({1'b0, wr_data[6:0]}, 8'h00, 8'h59)) sec_q <= {1'b0, wr_data[6:0]};
          end
          A_MIN:  if (dec_in({1'b0, wr_data[6:0]}, 8'h00, 8'h59)) min_q <= {1'b0, wr_data[6:0]};
          A_HR:   if (dec_in({2'b0, wr_data[5:0]}, 8'h00, 8'h23)) hr_q <= {2'b0, wr_data[5:0]};
          A_WDAY: begin
            wday_q <= {5'b0, wr_data[2:0]};
            cent_q <= wr_data[6];
          end
          A_DATE: if (dec_in({2'b0, wr_data[5:0]}, 8'h01, 8'h39)) date_q <= {2'b0, wr_data[5:0]};
          A_MON:  if (dec_in({3'b0, wr_data[4:0]}, 8'h01, 8'h12)) mon_q <= {3'b0, wr_data[4:0]};
          A_YR:   if (dec_in(wr_data, 8'h00, 8'h99)) yr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl_q;
      A_SEC:   rd_data = {stop_q, sec_q[6:0]};
      A_MIN:   rd_data = min_q;
      A_HR:    rd_data = hr_q;
      A_WDAY:  rd_data = {1'b0, cent_q, 3'b000, wday_q[2:0]};
      A_DATE:  rd_data = date_q;
      A_MON:   rd_data = mon_q;
      default: rd_data = yr_q;
    endcase
  end

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));
  p_hr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_q <= 8'h23) && (hr_q[3:0] <= 4'd9));
  p_mon_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_q >= 8'h01) && (mon_q <= 8'h12));
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(date_q)));
  p_ctrl_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));
  p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !stop_q && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));
  p_date_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    date_q != 8'h00);
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_en && addr == A_MIN) |=> $stable(hr_q));
endmodule

// File: tb/rtc_bcd_regs_test.sv
`timescale 1ns/1ps
module rtc_bcd_regs_test;
  logic clk = 0, rst_n = 0, tick_1hz = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int n_chk = 0, n_bad = 0;
  int m_ctrl, m_stop, m_sec, m_min, m_hr, m_wday, m_cent, m_date, m_mon, m_yr;

  always #2 clk = ~clk;

  rtc_bcd_regs #(.AW(3)) uut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  function automatic int bcd(input int n); return ((n / 10) << 4) | (n % 10); endfunction
  function automatic bit dok(input int v); return (v & 15) <= 9 && (v >> 4) <= 9; endfunction
  function automatic int dec(input int v); return (v >> 4) * 10 + (v & 15); endfunction

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return (m_stop << 7) | bcd(m_sec);
      2: return bcd(m_min);
      3: return bcd(m_hr);
      4: return (m_cent << 6) | (m_wday & 7);
      5: return bcd(m_date);
      6: return bcd(m_mon);
      default: return bcd(m_yr);
    endcase
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_reset();
    m_ctrl = 0; m_stop = 0; m_sec = 0; m_min = 0; m_hr = 0;
    m_wday = 1; m_cent = 0; m_date = 1; m_mon = 1; m_yr = 0;
  endtask

  task automatic m_tick();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wday = (m_wday >= 7) ? 1 : m_wday + 1;
    if (m_date < dim(m_mon, m_yr)) begin m_date++; return; end
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr = (m_yr + 1) % 100;
  endtask

  task automatic m_write(input int a, input int d);
    int v;
    case (a)
      0: m_ctrl = (d & 8'h5F) | 8'h90;
      1: begin m_stop = (d >> 7) & 1; v = d & 8'h7F; if (dok(v) && dec(v) <= 59) m_sec = dec(v); end
      2: begin v = d & 8'h7F; if (dok(v) && dec(v) <= 59) m_min = dec(v); end
      3: begin v = d & 8'h3F; if (dok(v) && dec(v) <= 23) m_hr = dec(v); end
      4: begin m_wday = d & 7; m_cent = (d >> 6) & 1; end
      5: begin v = d & 8'h3F; if (dok(v) && v != 0) m_date = dec(v); end
      6: begin v = d & 8'h1F; if (dok(v) && dec(v) >= 1 && dec(v) <= 12) m_mon = dec(v); end
      default: if (dok(d)) m_yr = dec(d);
    endcase
  endtask

  task automatic step(input bit we, input int a, input int d, input bit tk);
    @(negedge clk);
    wr_en = we; addr = 3'(a); wr_data = 8'(d); tick_1hz = tk;
    @(posedge clk); #1;
    if (tk && !m_stop && !(we && a != 0)) m_tick();
    if (we) m_write(a, d);
    wr_en = 0; tick_1hz = 0;
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #0.4;
      n_chk++;
      if (rd_data !== 8'(exp_rd(a))) begin
        n_bad++;
        $display("FAIL %s addr %0d actual=%02h expected=%02h", tag, a, rd_data, exp_rd(a));
      end
    end
  endtask

  task automatic set_time(input int yr, input int mo, input int dt, input int hr, input int mi, input int se, input int wd);
    step(1, 7, yr, 0); step(1, 6, mo, 0); step(1, 5, dt, 0);
    step(1, 3, hr, 0); step(1, 2, mi, 0); step(1, 1, se, 0); step(1, 4, wd, 0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    m_reset();
    #9 rst_n = 1;
    check_all("R1 reset");

    // R7 control pattern
    step(1, 0, 8'hFF, 0); check_all("R7 ctrl ff");
    step(1, 0, 8'h00, 0); check_all("R7 ctrl 00");

    // R2 R3 R4 accepted and rejected writes, R11 readback
    set_time(8'h42, 8'h07, 8'h15, 8'h13, 8'h27, 8'h33, 8'h45); check_all("R11 R6 valid set");
    step(1, 1, 8'h60, 0); step(1, 1, 8'h5A, 0); step(1, 2, 8'h60, 0); check_all("R2 reject");
    step(1, 3, 8'h24, 0); step(1, 3, 8'h1A, 0); check_all("R3 reject");
    step(1, 5, 8'h00, 0); step(1, 5, 8'h40, 0); step(1, 6, 8'h13, 0); step(1, 6, 8'h00, 0);
    step(1, 7, 8'h9A, 0); step(1, 7, 8'hA0, 0); check_all("R4 reject");
    step(1, 3, 8'hE3, 0); step(1, 2, 8'hD9, 0); check_all("R3 R2 masked bits");

    // R5 stop freezes, resumes
    step(1, 1, 8'hD8, 0); check_all("R5 stop set with bad value");
    step(0, 0, 0, 1); step(0, 0, 0, 1); check_all("R5 frozen");
    step(1, 1, 8'h10, 0); step(0, 0, 0, 1); check_all("R5 resumed");

    // R8 full rollover, R9 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h07); step(0, 0, 0, 1); check_all("R8 R9 new century");
    // R9 leap year Feb
    set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h03); step(0, 0, 0, 1); check_all("R9 leap 28->29");
    step(1, 3, 8'h23, 0); step(1, 2, 8'h59, 0); step(1, 1, 8'h59, 0); step(0, 0, 0, 1); check_all("R9 leap 29->1");
    set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02); step(0, 0, 0, 1); check_all("R9 common Feb");
    set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h00); step(0, 0, 0, 1); check_all("R9 30-day");
    set_time(8'h10, 8'h04, 8'h35, 8'h23, 8'h59, 8'h59, 8'h05); step(0, 0, 0, 1); check_all("R9 overshoot date");

    // R10 write wins over tick
    set_time(8'h20, 8'h05, 8'h05, 8'h10, 8'h59, 8'h59, 8'h01);
    step(1, 2, 8'h30, 1); check_all("R10 min write with tick");
    step(1, 1, 8'h59, 0); step(1, 0, 8'h01, 1); check_all("R10 ctrl write keeps tick");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      r = $urandom_range(0, 9);
      if (r < 6) step(0, 0, 0, 1);
      else begin
        int a, d;
        a = $urandom_range(0, 7);
        if ($urandom_range(0, 1) == 1) d = $urandom_range(0, 255);
        else d = bcd($urandom_range(0, 99)) | (($urandom_range(0, 3) == 0) ? 8'h80 : 0);
        if (a == 1 && (d & 8'h80) && $urandom_range(0, 1) == 1) d = d & 8'h7F;
        step(1, a, d, $urandom_range(0, 1));
      end
      if (i % 10 == 9) check_all("R8 R11 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule